// File: doc/BRIEF.md
# Zero-Address Stack Execution Core

This block is a small execution core for a stack-oriented instruction set. It fetches fixed-length 8-bit instructions from an instruction ROM, which is set by a parameter. It operates on 16-bit words held in a 32-word data RAM, whose contents after reset are also set by a parameter. The arithmetic instructions name no operand. They take the two entries at the top of an internal 8-deep operand stack and leave the result there, so a postfix expression can be executed directly as a straight sequence of instructions.

Exactly two instructions carry a memory address. One copies a data word onto the stack and the other moves the top of the stack back into data memory. A HALT instruction parks the core, and a start pulse resumes execution at the instruction after the HALT. A single ROM can therefore hold several programs, placed one after another. A stack fault parks the core for good and raises a sticky error flag, which only reset clears. A debug output shows the current top of the stack at all times. Reset also returns the data RAM to its initial image.

No port of this block carries a data stream, so it has no valid/ready handshake. All of its pins are plain control and status pins.

Top module: `stk_core`

## Requirements
- R1: After reset, halted is 1, stack_err is 0, dbg_top is 0, the stack is empty and the next fetch is taken from ROM address 0.
- R2: A start pulse sampled while halted is 1 and stack_err is 0 makes halted fall after that clock edge. Every instruction then takes one fetch cycle followed by one execute cycle, and the program counter advances by one per instruction.
- R3: The instruction word holds the opcode in bits [7:5] and a data address in bits [4:0]. Opcode 0 (push) copies data word [address] onto the stack, and the new top appears on dbg_top after its execute edge.
- R4: Opcode 1 (pop) writes the top entry to data word [address] in its execute cycle and removes it from the stack.
- R5: Opcodes 2 (add) and 4 (multiply) ignore the address field. Each replaces the top two entries with their sum or product, taken modulo 2^16.
- R6: Opcode 3 (subtract) replaces the top two entries with (entry below top) minus (top), taken modulo 2^16.
- R7: Opcode 7 (halt) returns the core to idle. halted rises after its execute edge, and the stack and data are kept. The next start resumes at the following ROM address.
- R8: Opcodes 5 and 6 do nothing and leave the stack unchanged.
- R9: A push onto a full stack (8 entries) sets stack_err, halts the core and leaves the stack unchanged.
- R10: A pop from an empty stack, or an arithmetic instruction run with fewer than two entries on the stack, sets stack_err, halts the core and leaves the stack unchanged.
- R11: stack_err stays set until reset, and while it is set a start pulse is ignored.
- R12: The program push X, push Y, multiply, push W, push U, multiply, add, pop Z leaves (X*Y)+(W*U) in data word Z.
- R13: dbg_top equals the top stack entry, or 0 when the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse that resumes execution from idle |
| halted | output | 1 | High while the core is idle |
| stack_err | output | 1 | Sticky stack overflow or underflow flag |
| dbg_top | output | 16 | Current top of the stack, 0 when empty |

## Verification
Call the edge that samples start edge 0. halted is low after edge 0. Instruction k is fetched at edge 2k+1 and executed at edge 2k+2, so its effect on dbg_top and stack_err appears right after edge 2k+2. A program segment of n instructions that ends in a halt therefore raises halted after edge 2n. The bench counts falling edges from the start pulse and samples halted at edge 2n-1 and at edge 2n. It also compares halted, stack_err and dbg_top against a queue-based behavioural model at every falling edge, so that each instruction's result is checked in the exact cycle it is due.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MUL  = 3'd4,
    OP_NOP5 = 3'd5,
    OP_NOP6 = 3'd6,
    OP_HALT = 3'd7
  } opc_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_FETCH,
    PH_EXEC
  } phase_e;

  typedef enum logic [1:0] {
    SK_HOLD,
    SK_PUSH,
    SK_POP,
    SK_FOLD
  } stk_cmd_e;
endpackage

// File: rtl/stk_rom.sv
module stk_rom #(
  parameter int AW = 5,
  parameter int IW = 8,
  parameter logic [(2**AW)*IW-1:0] IMAGE = '0
) (
  input  logic [AW-1:0] addr,
  output logic [IW-1:0] word
);
  assign word = IMAGE[int'(addr)*IW +: IW];
endmodule

// File: rtl/stk_dram.sv
module stk_dram #(
  parameter int AW = 5,
  parameter int DW = 16,
  parameter logic [(2**AW)*DW-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 2**AW;

  logic [DW-1:0] cells [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) cells[i] <= INIT[i*DW +: DW];
    end else if (we) begin
      cells[addr] <= wdata;
    end
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/stk_stack.sv
module stk_stack
  import stk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stk_cmd_e      cmd,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] top,
  output logic [DW-1:0] under,
  output logic [CW-1:0] depth,
  output logic          full
);
  logic [DW-1:0] ent [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth <= '0;
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else begin
      case (cmd)
        SK_PUSH: begin
          ent[IW'(depth)] <= din;
          depth           <= depth + CW'(1);
        end
        SK_POP:  depth <= depth - CW'(1);
        SK_FOLD: begin
          ent[IW'(depth - CW'(2))] <= din;
          depth                    <= depth - CW'(1);
        end
        default: ;
      endcase
    end
  end

  assign full  = (depth == CW'(DEPTH));
  assign top   = (depth == '0) ? '0 : ent[IW'(depth - CW'(1))];
  assign under = (depth < CW'(2)) ? '0 : ent[IW'(depth - CW'(2))];
endmodule

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int DW = 16
) (
  input  opc_e          op,
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  output logic [DW-1:0] res
);
  always_comb begin
    case (op)
      OP_ADD:  res = lhs + rhs;
      OP_SUB:  res = lhs - rhs;
      OP_MUL:  res = lhs * rhs;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/stk_core.sv
module stk_core
  import stk_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 5,
  parameter int OPC_W = 3,
  parameter int DEPTH = 8,
  parameter logic [(2**AW)*(OPC_W+AW)-1:0] ROM_IMAGE =
    {{((2**AW)-10)*(OPC_W+AW){1'b0}}, 80'hE00A2A40800403800201},
  parameter logic [(2**AW)*DW-1:0] DATA_INIT =
    {{((2**AW)-5)*DW{1'b0}}, 16'd11, 16'd7, 16'd5, 16'd3, 16'd0}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          halted,
  output logic          stack_err,
  output logic [DW-1:0] dbg_top
);
  localparam int IW = OPC_W + AW;
  localparam int CW = $clog2(DEPTH + 1);

  phase_e        phase;
  logic [AW-1:0] pc;
  logic [IW-1:0] ir;
  logic          err_q;

  logic [IW-1:0] rom_word;
  opc_e          opc;
  logic [AW-1:0] oaddr;
  stk_cmd_e      cmd;
  logic          mem_we;
  logic          fault;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] alu_res;
  logic [DW-1:0] stk_din;
  logic [DW-1:0] stk_top;
  logic [DW-1:0] stk_under;
  logic [CW-1:0] stk_depth;
  logic          stk_full;

  assign opc   = opc_e'(ir[IW-1 -: OPC_W]);
  assign oaddr = ir[AW-1:0];

  stk_rom #(.AW(AW), .IW(IW), .IMAGE(ROM_IMAGE)) u_rom (
    .addr (pc),
    .word (rom_word)
  );

  stk_dram #(.AW(AW), .DW(DW), .INIT(DATA_INIT)) u_dram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .addr  (oaddr),
    .wdata (stk_top),
    .rdata (mem_rdata)
  );

  stk_alu #(.DW(DW)) u_alu (
    .op  (opc),
    .lhs (stk_under),
    .rhs (stk_top),
    .res (alu_res)
  );

  stk_stack #(.DEPTH(DEPTH), .DW(DW)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (cmd),
    .din   (stk_din),
    .top   (stk_top),
    .under (stk_under),
    .depth (stk_depth),
    .full  (stk_full)
  );

  // Execute-cycle decode: stack command, memory write and fault detection.
  always_comb begin
    cmd    = SK_HOLD;
    mem_we = 1'b0;
    fault  = 1'b0;
    if (phase == PH_EXEC) begin
      case (opc)
        OP_PUSH: begin
          if (stk_full) fault = 1'b1;
          else          cmd   = SK_PUSH;
        end
        OP_POP: begin
          if (stk_depth == '0) begin
            fault = 1'b1;
          end else begin
            cmd    = SK_POP;
            mem_we = 1'b1;
          end
        end
        OP_ADD, OP_SUB, OP_MUL: begin
          if (stk_depth < CW'(2)) fault = 1'b1;
          else                    cmd   = SK_FOLD;
        end
        default: ;
      endcase
    end
  end

  assign stk_din = (opc == OP_PUSH) ? mem_rdata : alu_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      pc    <= '0;
      ir    <= '0;
      err_q <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start && !err_q) phase <= PH_FETCH;
        end
        PH_FETCH: begin
          ir    <= rom_word;
          pc    <= pc + AW'(1);
          phase <= PH_EXEC;
        end
        PH_EXEC: begin
          if (fault) begin
            err_q <= 1'b1;
            phase <= PH_IDLE;
          end else if (opc == OP_HALT) begin
            phase <= PH_IDLE;
          end else begin
            phase <= PH_FETCH;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign halted    = (phase == PH_IDLE);
  assign stack_err = err_q;
  assign dbg_top   = stk_top;
endmodule

// File: rtl/stk_core_chk.sv
module stk_core_chk #(
  parameter int DW    = 16,
  parameter int CW    = 4,
  parameter int DEPTH = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          halted,
  input logic          stack_err,
  input logic [DW-1:0] dbg_top,
  input logic [CW-1:0] depth
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |=> stack_err); // R11

  AST_START_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_err && start) |=> halted); // R11

  AST_ERR_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |-> halted); // R9

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !stack_err && start) |=> !halted); // R2

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !start) |=> ($stable(dbg_top) && $stable(depth))); // R7

  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CW'(DEPTH)); // R9

  AST_DEPTH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((depth == $past(depth)) || (depth == $past(depth) + CW'(1))
              || (depth + CW'(1) == $past(depth)))); // R5
endmodule

bind stk_core stk_core_chk #(.DW(DW), .CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .halted    (halted),
  .stack_err (stack_err),
  .dbg_top   (dbg_top),
  .depth     (stk_depth)
);

// File: tb/stk_core_tb.sv
`timescale 1ns/1ps
module stk_core_tb;
  localparam logic [15:0] XV = 16'd3, YV = 16'd5, WV = 16'd7, UV = 16'd11;

  localparam logic [511:0] DATA = {{23{16'h0000}}, 16'h0100, 16'h0300,
    16'h0009, 16'h0005, UV, WV, YV, XV, 16'h0000};

  // seg1 @0: postfix Z=(X*Y)+(W*U) with Z at 10; seg2 @10: sub/wrap/nop; seg3 @21: underflow
  localparam logic [255:0] MAIN_ROM = {{7{8'h00}},
    8'h40, 8'h0D, 8'h2D, 8'h2C,
    8'hE0, 8'hA0, 8'h40, 8'h80, 8'h08, 8'h07, 8'h0B, 8'h2B, 8'h60, 8'h06, 8'h05,
    8'hE0, 8'h0A, 8'h2A, 8'h40, 8'h80, 8'h04, 8'h03, 8'h80, 8'h02, 8'h01};

  localparam logic [255:0] OVF_ROM = {{22{8'h00}}, 8'hE0, {9{8'h01}}};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_a = 1'b0;
  logic        start_b = 1'b0;
  logic        halted_a, err_a, halted_b, err_b;
  logic [15:0] top_a, top_b;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  stk_core #(.ROM_IMAGE(MAIN_ROM), .DATA_INIT(DATA)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start_a),
    .halted(halted_a), .stack_err(err_a), .dbg_top(top_a));

  stk_core #(.ROM_IMAGE(OVF_ROM), .DATA_INIT(DATA)) u_dut_ovf (
    .clk(clk), .rst_n(rst_n), .start(start_b),
    .halted(halted_b), .stack_err(err_b), .dbg_top(top_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  // Behavioural reference model of u_dut
  int          m_phase;
  int          m_pc;
  logic [7:0]  m_ir;
  logic        m_err;
  logic [15:0] m_stk[$];
  logic [15:0] m_mem[32];
  logic [15:0] m_a, m_b;
  logic        m_fault;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_pc = 0; m_ir = '0; m_err = 1'b0;
      m_stk.delete();
      for (int i = 0; i < 32; i++) m_mem[i] = DATA[i*16 +: 16];
    end else begin
      case (m_phase)
        0: if (start_a && !m_err) m_phase = 1;
        1: begin
          m_ir = MAIN_ROM[m_pc*8 +: 8];
          m_pc = (m_pc + 1) % 32;
          m_phase = 2;
        end
        default: begin
          m_fault = 1'b0;
          m_phase = 1;
          case (m_ir[7:5])
            3'd0: if (m_stk.size() >= 8) m_fault = 1'b1;
                  else m_stk.push_back(m_mem[m_ir[4:0]]);
            3'd1: if (m_stk.size() == 0) m_fault = 1'b1;
                  else m_mem[m_ir[4:0]] = m_stk.pop_back();
            3'd2, 3'd3, 3'd4: begin
              if (m_stk.size() < 2) m_fault = 1'b1;
              else begin
                m_b = m_stk.pop_back();
                m_a = m_stk.pop_back();
                if (m_ir[7:5] == 3'd2)      m_stk.push_back(m_a + m_b);
                else if (m_ir[7:5] == 3'd3) m_stk.push_back(m_a - m_b);
                else                        m_stk.push_back(m_a * m_b);
              end
            end
            3'd7: m_phase = 0;
            default: ;
          endcase
          if (m_fault) begin
            m_err = 1'b1;
            m_phase = 0;
          end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 R7 model halted", {31'd0, halted_a}, {31'd0, (m_phase == 0)});
      chk("R9 R10 model stack_err", {31'd0, err_a}, {31'd0, m_err});
      chk("R3 R4 R5 R6 R8 R13 model dbg_top", {16'd0, top_a},
          {16'd0, (m_stk.size() == 0) ? 16'd0 : m_stk[m_stk.size()-1]});
    end
  end

  // Pulse start, then check halted at edges 2n-1 and 2n after the sampling edge.
  task automatic run_seg(input int n, input string req);
    @(negedge clk); start_a = 1'b1;
    @(negedge clk); start_a = 1'b0;
    chk({req, " halted falls after start"}, {31'd0, halted_a}, 32'd0);
    repeat (2*n - 1) @(negedge clk);
    chk({req, " still running at edge 2n-1"}, {31'd0, halted_a}, 32'd0);
    @(negedge clk);
    chk({req, " halted at edge 2n"}, {31'd0, halted_a}, 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 halted after reset", {31'd0, halted_a}, 32'd1);
    chk("R1 stack_err after reset", {31'd0, err_a}, 32'd0);
    chk("R1 dbg_top after reset", {16'd0, top_a}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle without start", {31'd0, halted_a}, 32'd1);

    // seg1: postfix expression R12, R2, R7
    run_seg(10, "R2");
    chk("R12 Z=(X*Y)+(W*U)", {16'd0, top_a}, {16'd0, 16'(XV*YV + WV*UV)});
    chk("R7 no error after halt", {31'd0, err_a}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R7 top kept while idle", {16'd0, top_a}, {16'd0, 16'(XV*YV + WV*UV)});

    // seg2: subtract order, multiply wrap, reserved opcode, resume after halt
    run_seg(11, "R7 resume");
    chk("R6 R5 under-top minus top, wrapped product", {16'd0, top_a}, 32'h0000FFFC);

    // seg3: underflow on add after emptying the stack
    run_seg(4, "R10");
    chk("R10 stack_err set", {31'd0, err_a}, 32'd1);
    chk("R10 top unchanged by fault", {16'd0, top_a}, {16'd0, 16'(XV*YV + WV*UV)});

    // R11: start ignored while error set
    @(negedge clk); start_a = 1'b1;
    @(negedge clk); start_a = 1'b0;
    chk("R11 start ignored (halted)", {31'd0, halted_a}, 32'd1);
    repeat (4) @(negedge clk);
    chk("R11 still halted", {31'd0, halted_a}, 32'd1);
    chk("R11 error sticky", {31'd0, err_a}, 32'd1);

    // overflow instance: nine pushes of X
    @(negedge clk); start_b = 1'b1;
    @(negedge clk); start_b = 1'b0;
    repeat (17) @(negedge clk);
    chk("R9 no error before ninth push", {31'd0, err_b}, 32'd0);
    chk("R9 running before ninth push", {31'd0, halted_b}, 32'd0);
    @(negedge clk);
    chk("R9 overflow sets stack_err", {31'd0, err_b}, 32'd1);
    chk("R9 overflow halts", {31'd0, halted_b}, 32'd1);
    chk("R9 top unchanged by overflow", {16'd0, top_b}, {16'd0, XV});

    // reset clears everything and restarts from address 0
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears error", {31'd0, err_a}, 32'd0);
    chk("R1 reset empties stack", {16'd0, top_a}, 32'd0);
    chk("R1 reset clears overflow error", {31'd0, err_b}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run_seg(10, "R1 restart");
    chk("R1 R12 rerun from address 0", {16'd0, top_a}, {16'd0, 16'(XV*YV + WV*UV)});

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule